// File: doc/BRIEF.md
# Open-Drain Output Port with Beep Tone

This block drives two open-drain output pins of a low-power tuning controller. Each pin has a storage latch written by the processor through an "output write" strobe. The first pin can instead carry a square-wave beep tone. A separate "beep command" strobe selects that function and one of two tone pitches. The second pin is always a plain latched output. Each pin is modelled by one signal: high means the pin is pulled low, and low means the pin floats.

While the first pin carries the tone, output writes still update its latch, but the waveform on the pin does not change. When the pin returns to latched output, it shows the stored value at once. A backup (low-power) input floats both pins. They stay floating after backup ends until the processor issues an output write or a beep command.

The tone is divided from a tick strobe supplied at the 75 kHz base rate. With the default divisors, the tones are 1.5 kHz and 3 kHz.

Top module: `opb_beep_port`

## Requirements
- R1: After reset both pins float (`pin_pull` = 2'b00), both latches hold 1, and pin 0 is in latched-output function.
- R2: In latched-output function, an output write stores `out_data`. From the next cycle, pin i is pulled low exactly when bit i of the written value is 0.
- R3: A beep command with `beep_ctl[2]`=1 places pin 0 in tone function. A beep command with `beep_ctl[2]`=0 returns it to latched-output function.
- R4: `beep_ctl[1:0]`=2'b00 selects a tone period of DIV_LO ticks, and any other code selects DIV_HI ticks. In each period, pin 0 is pulled low for the first floor(DIV/2) ticks and floats for the remaining ticks.
- R5: Every beep command that selects tone function clears the divider. Pin 0 is pulled low from the next cycle, and that first low phase has full length.
- R6: An output write made while pin 0 is in tone function leaves the pin 0 waveform unchanged and still stores the new bit in the latch.
- R7: On return to latched-output function, pin 0 shows the stored latch value from the next cycle.
- R8: Pin 1 never carries the tone. It changes only through output writes and through entering or leaving the floating state.
- R9: While `backup` is high both pins float. After `backup` falls, both pins stay floating until an output write or a beep command occurs.
- R10: The tone divider advances only in cycles where `tick` is high. Without tick, pin 0 holds its level.
- R11: A beep command does not change either output latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle strobe at the 75 kHz tone base rate |
| out_wr | input | 1 | Output write strobe |
| out_data | input | 2 | Latch values for pin 1 and pin 0 (0 pulls the pin low) |
| beep_wr | input | 1 | Beep command strobe |
| beep_ctl | input | 3 | Bit 2 selects tone function for pin 0; bits 1:0 select the pitch |
| backup | input | 1 | Backup mode; floats both pins |
| pin_pull | output | 2 | Per-pin drive-low enable (1 = pulled low, 0 = floating) |

## Verification
The bench builds the block with DIV_LO=8 and DIV_HI=5. With these values, several complete tone periods of both pitches fit into a few dozen cycles. The odd divisor exercises the unequal low and float phases (2 low, 3 floating). With `tick` held high, each clock edge is one tone step, so the bench can compare every sampled cycle against the expected period pattern. A gated-tick scenario then checks that the divider holds its count when no tick arrives.

// File: rtl/opb_pkg.sv
package opb_pkg;

  typedef enum logic {
    PIN_LATCHED = 1'b0,
    PIN_TONE    = 1'b1
  } pin_fn_e;

  localparam int unsigned PIN_COUNT = 2;
  localparam int unsigned TONE_PIN  = 0;
  localparam int unsigned CTL_W     = 3;

  function automatic int unsigned max_div(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/opb_port_latch.sv
module opb_port_latch
  import opb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 out_wr,
  input  logic [PIN_COUNT-1:0] out_data,
  input  logic                 beep_wr,
  input  logic [CTL_W-1:0]     beep_ctl,
  input  logic                 backup,
  output logic [PIN_COUNT-1:0] latch_q,
  output pin_fn_e              fn_q,
  output logic                 code_hi_q,
  output logic                 float_q,
  output logic                 tone_clr
);

  logic [PIN_COUNT-1:0] latch_d;
  pin_fn_e              fn_d;
  logic                 code_hi_d;
  logic                 float_d;
  logic                 latch_en;
  logic                 cmd_en;

  assign latch_en = out_wr;
  assign cmd_en   = beep_wr;
  assign tone_clr = beep_wr && beep_ctl[2];

  always_comb begin
    latch_d   = latch_q;
    fn_d      = fn_q;
    code_hi_d = code_hi_q;
    float_d   = float_q;
    if (latch_en) begin
      latch_d = out_data;
    end
    if (cmd_en) begin
      fn_d      = beep_ctl[2] ? PIN_TONE : PIN_LATCHED;
      code_hi_d = (beep_ctl[1:0] != 2'b00);
    end
    if (backup) begin
      float_d = 1'b1;
    end else if (latch_en || cmd_en) begin
      float_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '1;
      fn_q      <= PIN_LATCHED;
      code_hi_q <= 1'b0;
      float_q   <= 1'b0;
    end else begin
      latch_q   <= latch_d;
      fn_q      <= fn_d;
      code_hi_q <= code_hi_d;
      float_q   <= float_d;
    end
  end

endmodule

// File: rtl/opb_tone_div.sv
module opb_tone_div
  import opb_pkg::*;
#(
  parameter int unsigned DIV_LO = 50,
  parameter int unsigned DIV_HI = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic run,
  input  logic sel_hi,
  output logic tone_low
);

  localparam int unsigned DIV_MAX = max_div(DIV_LO, DIV_HI);
  localparam int unsigned CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(DIV_LO / 2);
  localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(DIV_HI / 2);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] half;
  logic             cnt_en;

  assign last   = sel_hi ? LAST_HI : LAST_LO;
  assign half   = sel_hi ? HALF_HI : HALF_LO;
  assign cnt_en = clr || (run && tick);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run && tick) begin
      cnt_d = (cnt_q >= last) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tone_low = run && (cnt_q < half);

endmodule

// File: rtl/opb_pin_drive.sv
module opb_pin_drive
  import opb_pkg::*;
(
  input  logic [PIN_COUNT-1:0] latch_q,
  input  pin_fn_e              fn_q,
  input  logic                 tone_low,
  input  logic                 float_q,
  input  logic                 backup,
  output logic [PIN_COUNT-1:0] pin_pull
);

  logic released;

  assign released = float_q || backup;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    if (i == TONE_PIN) begin : g_tone
      assign pin_pull[i] = !released &&
                           ((fn_q == PIN_TONE) ? tone_low : !latch_q[i]);
    end else begin : g_plain
      assign pin_pull[i] = !released && !latch_q[i];
    end
  end

endmodule

// File: rtl/opb_beep_port.sv
module opb_beep_port
  import opb_pkg::*;
#(
  parameter int unsigned DIV_LO = 50,
  parameter int unsigned DIV_HI = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       out_wr,
  input  logic [1:0] out_data,
  input  logic       beep_wr,
  input  logic [2:0] beep_ctl,
  input  logic       backup,
  output logic [1:0] pin_pull
);

  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  logic [PIN_COUNT-1:0] latch_q;
  pin_fn_e              fn_q;
  logic                 code_hi_q;
  logic                 float_q;
  logic                 tone_clr;
  logic                 tone_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  opb_port_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .out_wr    (out_wr),
    .out_data  (out_data),
    .beep_wr   (beep_wr),
    .beep_ctl  (beep_ctl),
    .backup    (backup),
    .latch_q   (latch_q),
    .fn_q      (fn_q),
    .code_hi_q (code_hi_q),
    .float_q   (float_q),
    .tone_clr  (tone_clr)
  );

  opb_tone_div #(
    .DIV_LO (DIV_LO),
    .DIV_HI (DIV_HI)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .clr      (tone_clr),
    .run      (fn_q == PIN_TONE),
    .sel_hi   (code_hi_q),
    .tone_low (tone_low)
  );

  opb_pin_drive u_drive (
    .latch_q  (latch_q),
    .fn_q     (fn_q),
    .tone_low (tone_low),
    .float_q  (float_q),
    .backup   (backup),
    .pin_pull (pin_pull)
  );

endmodule

// File: rtl/opb_beep_port_chk.sv
module opb_beep_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       out_wr,
  input logic [1:0] out_data,
  input logic       beep_wr,
  input logic [2:0] beep_ctl,
  input logic       backup,
  input logic [1:0] pin_pull
);

  AST_BACKUP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    backup |-> pin_pull == 2'b00); // R9

  AST_FLOAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(backup) && !$past(out_wr) && !$past(beep_wr)) |-> pin_pull == 2'b00); // R9

  AST_PIN1_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && !backup) |=> (backup || (pin_pull[1] == !$past(out_data[1])))); // R2

  AST_TONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (beep_wr && beep_ctl[2] && !backup) |=> (backup || pin_pull[0])); // R5

  AST_PIN1_NO_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(out_wr) && !$past(beep_wr) && !$past(backup) && !backup)
      |-> $stable(pin_pull[1])); // R8

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(out_wr) && !$past(beep_wr) && !$past(backup) && !backup)
      |-> $stable(pin_pull[0])); // R10

endmodule

bind opb_beep_port opb_beep_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick     (tick),
  .out_wr   (out_wr),
  .out_data (out_data),
  .beep_wr  (beep_wr),
  .beep_ctl (beep_ctl),
  .backup   (backup),
  .pin_pull (pin_pull)
);

// File: tb/sim_opb_beep_port.sv
`timescale 1ns/1ps
module sim_opb_beep_port;

  localparam int unsigned DIV_LO = 8;
  localparam int unsigned DIV_HI = 5;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       out_wr;
  logic [1:0] out_data;
  logic       beep_wr;
  logic [2:0] beep_ctl;
  logic       backup;
  logic [1:0] pin_pull;

  int n_checks;
  int n_errors;

  opb_beep_port #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .out_wr(out_wr), .out_data(out_data),
    .beep_wr(beep_wr), .beep_ctl(beep_ctl), .backup(backup), .pin_pull(pin_pull)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: pin_pull actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_out(input logic [1:0] d);
    @(negedge clk);
    out_wr = 1'b1; out_data = d;
    @(negedge clk);
    out_wr = 1'b0;
  endtask

  task automatic do_beep(input logic [2:0] c);
    @(negedge clk);
    beep_wr = 1'b1; beep_ctl = c;
    @(negedge clk);
    beep_wr = 1'b0;
  endtask

  // Samples 2*div cycles after a tone command; optional output write in sample 0.
  task automatic tone_run(input string req, input int unsigned div, input logic pin1_pull,
                          input logic shadow, input logic [1:0] sd);
    int bad = 0;
    logic p1 = pin1_pull;
    for (int j = 0; j < 2 * div; j++) begin
      logic exp0 = ((j % div) < (div / 2));
      if (j >= 1 && shadow) p1 = !sd[1];
      if (pin_pull !== {p1, exp0}) begin
        bad++;
        $display("FAIL %s: sample %0d pin_pull actual %b expected %b", req, j, pin_pull, {p1, exp0});
      end
      if (j == 0 && shadow) begin out_wr = 1'b1; out_data = sd; end
      @(negedge clk);
      out_wr = 1'b0;
    end
    n_checks++;
    if (bad != 0) n_errors++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset float", pin_pull, 2'b00);
  endtask

  task automatic t_latched();
    do_out(2'b10); check("R2 write 10", pin_pull, 2'b01);
    do_out(2'b01); check("R2 write 01", pin_pull, 2'b10);
    do_out(2'b00); check("R2 write 00", pin_pull, 2'b11);
  endtask

  task automatic t_tone_lo();
    do_beep(3'b100);
    tone_run("R3 R4 R5 R8 low pitch", DIV_LO, 1'b1, 1'b0, 2'b00);
  endtask

  task automatic t_tone_hi_shadow();
    do_beep(3'b110);
    tone_run("R4 R5 R6 high pitch with shadow write", DIV_HI, 1'b1, 1'b1, 2'b01);
  endtask

  task automatic t_return();
    do_beep(3'b000);
    check("R7 latch shown on return", pin_pull, 2'b10);
    do_beep(3'b011);
    check("R11 beep command keeps latches", pin_pull, 2'b10);
    do_out(2'b11);
    do_beep(3'b001);
    check("R11 latches unchanged", pin_pull, 2'b00);
  endtask

  task automatic t_backup();
    do_out(2'b10);
    @(negedge clk); backup = 1'b1;
    @(negedge clk); check("R9 backup float", pin_pull, 2'b00);
    do_out(2'b00); check("R9 write in backup floats", pin_pull, 2'b00);
    @(negedge clk); backup = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 float held after backup", pin_pull, 2'b00);
    do_out(2'b10); check("R9 output write releases", pin_pull, 2'b01);
    @(negedge clk); backup = 1'b1;
    @(negedge clk); backup = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 float held again", pin_pull, 2'b00);
    do_beep(3'b000); check("R9 beep command releases", pin_pull, 2'b01);
  endtask

  task automatic t_tick_gate();
    do_beep(3'b100);
    tick = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 no tick stays low", pin_pull, 2'b01);
    tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    check("R10 count 5 released", pin_pull, 2'b00);
    repeat (6) @(negedge clk);
    check("R10 no tick stays released", pin_pull, 2'b00);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 wrapped to low", pin_pull, 2'b01);
  endtask

  initial begin
    n_checks = 0; n_errors = 0;
    tick = 1'b1; out_wr = 1'b0; out_data = 2'b00;
    beep_wr = 1'b0; beep_ctl = 3'b000; backup = 1'b0;
    t_reset();
    t_latched();
    t_tone_lo();
    t_tone_hi_shadow();
    t_return();
    t_backup();
    t_tick_gate();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule